// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

The sequencer produces the row timing for a sensor array read with a rolling shutter. One pulse on the frame start input begins a frame. The block then issues one row-reset command per row period, walking from the top row downwards. A second pointer follows a fixed number of row periods behind and issues the row-read commands in the same order. Because both pointers advance at the same rate and the gap between them never changes, every row integrates for exactly the same time. Each row's window starts one row period after the window of the row above it.

The row count, the row period in clocks and the exposure in row periods are plain configuration inputs. They are captured when a frame is accepted and held for the whole frame. Commands are single-cycle strobes, each carrying a row index, and the strobes have no ready input. The receiver must take a strobe in the cycle it appears, because stalling a command would change the exposure of that row. Start-of-frame and end-of-frame flags mark the first reset and the last read. A busy output stays high from the first reset through the last read.

Top module: `rolling_shutter_seq`

## Requirements
- R1: After reset, no strobe, flag or busy output is asserted until a frame is accepted.
- R2: A frame is accepted when `frame_start` is high at a clock edge while `busy` is low and `cfg_rows` is nonzero. In the next cycle `busy` rises, `row_reset_vld` is high with `row_reset_idx` = 0, and `frame_sof` is high. `frame_sof` is high in that cycle only.
- R3: Let P be the effective row period. Counting cycles from k = 0, the first cycle after acceptance, the reset of row r (0 ≤ r < N) is issued at cycle k = r·P. That is exactly one reset per row period, in increasing row order, and no other reset strobes occur.
- R4: The read of row r is issued at cycle k = (r+E)·P + 1, where E is the exposure in row periods. So the gap from reset to read is the same E·P+1 cycles for every row, and no other read strobes occur.
- R5: With E = 0, each row is read one cycle after its own reset, inside the same row period.
- R6: A `cfg_period` value of 0 or 1 is treated as a row period of 2 clocks.
- R7: Once the reset of row N−1 has been issued, no further resets occur while the remaining reads drain. `frame_eof` is high together with the read of row N−1. `busy` is high from k = 0 through that cycle and low in the cycle after it.
- R8: While `busy` is high, a `frame_start` pulse does not start a new frame or raise `frame_sof`. Changes on the configuration inputs during that time also have no effect on the frame in progress.
- R9: A `frame_start` pulse while `cfg_rows` = 0 is ignored, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Request to begin a frame |
| cfg_rows | input | ROW_W | Number of rows N in the frame |
| cfg_period | input | PER_W | Row period in clocks (values below 2 act as 2) |
| cfg_exposure | input | ROW_W | Exposure E in row periods |
| row_reset_vld | output | 1 | Row-reset command strobe |
| row_reset_idx | output | ROW_W | Row to reset, meaningful while the strobe is high |
| row_read_vld | output | 1 | Row-read command strobe |
| row_read_idx | output | ROW_W | Row to read, meaningful while the strobe is high |
| frame_sof | output | 1 | First reset of the frame |
| frame_eof | output | 1 | Last read of the frame |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps row counts, periods and exposures, including periods of 0 and 1, exposure 0, exposure longer than the frame, and single-row frames. It predicts every strobe cycle by arithmetic. A design that placed the read in the wrong phase, or a slot early or late, would show an exposure that varies by row, or a read appearing before its reset when E = 0. A reset pointer that kept running past the last row would issue out-of-range reset strobes during the drain. An end flag or busy output off by one would make the frame overlap with the next accepted start. A mid-frame start pulse with altered configuration tests whether the block restarts or retimes a running frame. A start with zero rows tests whether the block hangs with busy stuck high.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned RSG_MIN_PERIOD = 2;
  localparam int unsigned RSG_NUM_PTRS   = 2;
  typedef enum int unsigned {PTR_RESET = 0, PTR_READ = 1} rsg_ptr_e;
endpackage

// File: rtl/rsg_period_timer.sv
module rsg_period_timer #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             reset_phase,
  output logic             read_phase,
  output logic             slot_end
);
  logic [PER_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clear)  phase <= '0;
    else if (run)    phase <= slot_end ? '0 : phase + 1'b1;
  end

  // Reset strobes sit on the first clock of a slot, reads on the second.
  assign reset_phase = (phase == '0);
  assign read_phase  = (phase == PER_W'(1));
  assign slot_end    = (phase == period - 1'b1);
endmodule

// File: rtl/rsg_row_ptr.sv
module rsg_row_ptr #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             step,
  input  logic [ROW_W-1:0] last,
  output logic [ROW_W-1:0] idx,
  output logic             live
);
  logic fin;

  assign live = enable && !fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      fin <= 1'b1;
    end else if (clear) begin
      idx <= '0;
      fin <= 1'b0;
    end else if (step && live) begin
      if (idx == last) fin <= 1'b1;
      else             idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/rolling_shutter_seq.sv
module rolling_shutter_seq #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [ROW_W-1:0] cfg_exposure,
  output logic             row_reset_vld,
  output logic [ROW_W-1:0] row_reset_idx,
  output logic             row_read_vld,
  output logic [ROW_W-1:0] row_read_idx,
  output logic             frame_sof,
  output logic             frame_eof,
  output logic             busy
);
  import rsg_pkg::*;

  localparam logic [PER_W-1:0] MIN_PER = PER_W'(RSG_MIN_PERIOD);

  logic             active;
  logic             accept;
  logic [ROW_W-1:0] last_q;
  logic [PER_W-1:0] per_q;
  logic [ROW_W-1:0] exp_q;
  logic [ROW_W-1:0] lag_cnt;
  logic             lag_done;
  logic             reset_phase, read_phase, slot_end;

  logic [RSG_NUM_PTRS-1:0] ptr_en;
  logic [RSG_NUM_PTRS-1:0] ptr_live;
  logic [ROW_W-1:0]        ptr_idx [RSG_NUM_PTRS];

  assign accept = frame_start && !active && (cfg_rows != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      last_q <= '0;
      per_q  <= MIN_PER;
      exp_q  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      last_q <= cfg_rows - 1'b1;
      per_q  <= (cfg_period < MIN_PER) ? MIN_PER : cfg_period;
      exp_q  <= cfg_exposure;
    end else if (frame_eof) begin
      active <= 1'b0;
    end
  end

  // Slots elapsed since the frame began, saturating at the exposure lag.
  assign lag_done = (lag_cnt == exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 lag_cnt <= '0;
    else if (accept)                            lag_cnt <= '0;
    else if (active && slot_end && !lag_done)   lag_cnt <= lag_cnt + 1'b1;
  end

  rsg_period_timer #(.PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .run         (active),
    .period      (per_q),
    .reset_phase (reset_phase),
    .read_phase  (read_phase),
    .slot_end    (slot_end)
  );

  for (genvar g = 0; g < RSG_NUM_PTRS; g++) begin : g_ptr
    if (g == PTR_RESET) begin : g_lead
      assign ptr_en[g] = 1'b1;
    end else begin : g_trail
      assign ptr_en[g] = lag_done;
    end
    rsg_row_ptr #(.ROW_W(ROW_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .enable (ptr_en[g]),
      .step   (active && slot_end),
      .last   (last_q),
      .idx    (ptr_idx[g]),
      .live   (ptr_live[g])
    );
  end

  assign row_reset_vld = active && ptr_live[PTR_RESET] && reset_phase;
  assign row_reset_idx = ptr_idx[PTR_RESET];
  assign row_read_vld  = active && ptr_live[PTR_READ] && read_phase;
  assign row_read_idx  = ptr_idx[PTR_READ];
  assign frame_sof     = row_reset_vld && (row_reset_idx == '0);
  assign frame_eof     = row_read_vld && (row_read_idx == last_q);
  assign busy          = active;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int unsigned ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             busy,
  input logic             row_reset_vld,
  input logic [ROW_W-1:0] row_reset_idx,
  input logic             row_read_vld,
  input logic [ROW_W-1:0] row_read_idx,
  input logic             frame_sof,
  input logic             frame_eof
);
  logic [ROW_W:0] rst_cnt;
  logic [ROW_W:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
      rd_cnt  <= '0;
    end else begin
      if (frame_sof)          rst_cnt <= (ROW_W+1)'(1);
      else if (row_reset_vld) rst_cnt <= rst_cnt + 1'b1;
      if (frame_sof)          rd_cnt  <= '0;
      else if (row_read_vld)  rd_cnt  <= rd_cnt + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (row_reset_vld || row_read_vld || frame_sof || frame_eof) |-> busy);
  p_sof_row0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> (row_reset_vld && row_reset_idx == '0));
  p_reset_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_reset_vld && !frame_sof) |-> ({1'b0, row_reset_idx} == rst_cnt));
  p_single_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_reset_vld && row_read_vld));
  p_read_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    row_read_vld |-> ({1'b0, row_read_idx} == rd_cnt && rd_cnt < rst_cnt));
  p_eof_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_eof |=> !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_start) |=> !frame_sof);
endmodule

bind rolling_shutter_seq rsg_checker #(.ROW_W(ROW_W)) i_rsg_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .busy          (busy),
  .row_reset_vld (row_reset_vld),
  .row_reset_idx (row_reset_idx),
  .row_read_vld  (row_read_vld),
  .row_read_idx  (row_read_idx),
  .frame_sof     (frame_sof),
  .frame_eof     (frame_eof)
);

// File: tb/test_rolling_shutter_seq.sv
module test_rolling_shutter_seq;
  localparam int ROW_W = 8;
  localparam int PER_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic [ROW_W-1:0] cfg_rows = '0;
  logic [PER_W-1:0] cfg_period = '0;
  logic [ROW_W-1:0] cfg_exposure = '0;
  logic             row_reset_vld, row_read_vld, frame_sof, frame_eof, busy;
  logic [ROW_W-1:0] row_reset_idx, row_read_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rolling_shutter_seq #(.ROW_W(ROW_W), .PER_W(PER_W)) i_rolling_shutter_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_rows(cfg_rows), .cfg_period(cfg_period), .cfg_exposure(cfg_exposure),
    .row_reset_vld(row_reset_vld), .row_reset_idx(row_reset_idx),
    .row_read_vld(row_read_vld), .row_read_idx(row_read_idx),
    .frame_sof(frame_sof), .frame_eof(frame_eof), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_frame(input int n, input int per, input int e);
    int pe;
    int k_last;
    string rtag;
    string ptag;
    bit disturb;
    pe = (per < 2) ? 2 : per;
    k_last = (n - 1 + e) * pe + 1;
    rtag = (e == 0) ? "R5" : "R4";
    ptag = (per < 2) ? "R6" : "R3";
    disturb = ((n + e) % 2 == 1) && (k_last >= 4);
    cfg_rows = ROW_W'(n);
    cfg_period = PER_W'(per);
    cfg_exposure = ROW_W'(e);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k <= k_last + 2; k++) begin
      int slot;
      int ph;
      bit e_rst;
      bit e_rd;
      bit e_eof;
      slot = k / pe;
      ph = k % pe;
      e_rst = (ph == 0) && (slot < n);
      e_rd  = (ph == 1) && (slot >= e) && (slot - e < n);
      e_eof = e_rd && (slot - e == n - 1);
      chk(row_reset_vld == e_rst, ptag, "reset strobe", row_reset_vld, e_rst);
      if (e_rst)
        chk(int'(row_reset_idx) == slot, ptag, "reset row", row_reset_idx, slot);
      chk(row_read_vld == e_rd, rtag, "read strobe", row_read_vld, e_rd);
      if (e_rd)
        chk(int'(row_read_idx) == slot - e, rtag, "read row", row_read_idx, slot - e);
      chk(frame_sof == (k == 0), "R2", "sof", frame_sof, k == 0);
      chk(frame_eof == e_eof, "R7", "eof", frame_eof, e_eof);
      chk(busy == (k <= k_last), (k > k_last) ? "R7" : "R8", "busy", busy, k <= k_last);
      if (disturb && k == 3) begin
        frame_start = 1'b1;
        cfg_rows = ROW_W'(n + 3);
        cfg_period = PER_W'(pe + 2);
        cfg_exposure = ROW_W'(e + 1);
      end else begin
        frame_start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int rows_set [4] = '{1, 2, 3, 5};
    int per_set  [5] = '{0, 1, 2, 3, 5};
    int exp_set  [5] = '{0, 1, 2, 4, 7};
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!busy && !row_reset_vld && !row_read_vld && !frame_sof && !frame_eof,
        "R1", "reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !row_reset_vld && !row_read_vld, "R1", "idle after reset", busy, 0);

    // R9: zero rows ignored
    cfg_rows = '0;
    cfg_period = PER_W'(3);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!busy && !row_reset_vld && !frame_sof, "R9", "zero-row start", busy, 0);
      @(negedge clk);
    end

    foreach (rows_set[a])
      foreach (per_set[b])
        foreach (exp_set[c])
          run_frame(rows_set[a], per_set[b], exp_set[c]);

    // Back-to-back frame after a single-row frame
    run_frame(1, 2, 0);
    run_frame(4, 3, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule